// File: doc/BRIEF.md
# Multiplexed Grid Scan Dimming Generator

This block generates the time-multiplexed drive pattern for a vacuum fluorescent display run at 1/2 duty (two grids) or 1/3 duty (three grids). A free-running scan counter divides the oscillator clock into bit times of four clocks each. Each grid owns a slot of 1024 bit times. Within a slot, the grid enable is active-low for a window of D bit times. The segment outputs show the pattern held for that grid during a window of D+3 bit times. The segment window opens three bit times before the grid window, and both windows close on the same bit time. D is the dimming count. It is taken from a 10-bit dimming code that saturates at 1016.

In master mode the block also drives a dimming pulse and a two-wire slot code, so that a second driver can follow the scan. In slave mode the block ignores its own timing. It drives segments from the grid pattern selected by the incoming slot code, and only while the incoming dimming pulse is high. Its grid enables stay high and its dimming and sync outputs stay low.

The dimming code and the duty select are captured only at the first clock of a display cycle. Every slot of a cycle therefore uses one consistent window.

Top module: `vfd_grid_scan`

## Requirements
- R1: After reset all segments are low, all grid enables are high, and the dimming and sync outputs are low. The captured dimming count is 0 and the captured duty is duplex. The first display cycle, 8192 clocks long, produces no pulse.
- R2: One bit time is 4 clocks and one slot is 1024 bit times. A display cycle has 2 slots when `duplex_sel` was high at the cycle start, and 3 slots when it was low.
- R3: In master mode the grid enable of the active slot (`grid_n[0]` for the first slot, `grid_n[1]` for the second, `grid_n[2]` for the third) is low from bit time 3 of the slot up to and including bit time D+2. It is high for the rest of the slot.
- R4: In master mode the segment window covers bit times 0 to D+2 of each slot. During the window `seg` equals the pattern input of the active slot and `dim_out` is high. Outside the window both are low.
- R5: During the segment window, `{sync_out1,sync_out2}` is 2'b10 in slot 1, 2'b01 in slot 2 and 2'b11 in slot 3. Outside the window both are 0.
- R6: D equals `dim_code` when the code is 1016 or less, and 1016 when it is larger.
- R7: A captured dimming count of 0 gives no grid, segment, dimming or sync pulse for the whole cycle.
- R8: `dim_code` and `duplex_sel` are captured only at the start of a display cycle. A change made during a cycle first acts in the next cycle.
- R9: In master mode `dim_in`, `sync_in1` and `sync_in2` have no effect on any output.
- R10: In slave mode (`master_sel` low), `grid_n` is 3'b111 and `dim_out`, `sync_out1` and `sync_out2` are 0. Decoding `{sync_in1,sync_in2}` as 10 = pattern 1, 01 = pattern 2 and 11 = pattern 3, `seg` shows the selected pattern while `dim_in` is high and is 0 while `dim_in` is low.
- R11: In slave mode a sync input code of `{sync_in1,sync_in2}` = 00 forces all segments off, whatever the level of `dim_in`.
- R12: At most one grid enable is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duplex_sel | input | 1 | 1 = two-slot cycle, 0 = three-slot cycle |
| master_sel | input | 1 | 1 = master (own timing), 0 = slave |
| dim_code | input | 10 | Dimming code, bit times per slot |
| pat_g1 | input | 56 | Segment pattern for grid 1 |
| pat_g2 | input | 56 | Segment pattern for grid 2 |
| pat_g3 | input | 56 | Segment pattern for grid 3 |
| dim_in | input | 1 | Slave dimming pulse from master |
| sync_in1 | input | 1 | Slave slot code, bit 1 |
| sync_in2 | input | 1 | Slave slot code, bit 2 |
| grid_n | output | 3 | Active-low grid enables |
| seg | output | 56 | Segment outputs, high = lit |
| dim_out | output | 1 | Master dimming pulse |
| sync_out1 | output | 1 | Master slot code, bit 1 |
| sync_out2 | output | 1 | Master slot code, bit 2 |

## Verification
The embedded properties check several rules on every cycle:
- No more than one grid enable is ever low.
- Every grid window is preceded by an open segment window.
- The slot code is non-zero whenever the dimming pulse is high.
- A zero count keeps the master dark.
- The captured count never exceeds 1016 and changes only at a cycle boundary.

The exact window edges (bit times 3 and D+2) can only be shown by the bench's timed scenarios. The same holds for the cycle length in each duty, the one-cycle delay of a new code, and the slave decode of each sync code.

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan #(
  parameter int SEGS        = 56,
  parameter int OSC_PER_BIT = 4,
  parameter int SLOT_BITS   = 1024,
  parameter int DIM_W       = 10,
  parameter int DIM_MAX     = 1016,
  parameter int LEAD        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            duplex_sel,
  input  logic            master_sel,
  input  logic [DIM_W-1:0] dim_code,
  input  logic [SEGS-1:0] pat_g1,
  input  logic [SEGS-1:0] pat_g2,
  input  logic [SEGS-1:0] pat_g3,
  input  logic            dim_in,
  input  logic            sync_in1,
  input  logic            sync_in2,
  output logic [2:0]      grid_n,
  output logic [SEGS-1:0] seg,
  output logic            dim_out,
  output logic            sync_out1,
  output logic            sync_out2
);
  localparam int PW = (OSC_PER_BIT > 1) ? $clog2(OSC_PER_BIT) : 1;
  localparam int BW = $clog2(SLOT_BITS);
  localparam int WW = ((DIM_W > BW) ? DIM_W : BW) + 2;

  logic [PW-1:0]    phase;
  logic [BW-1:0]    bitc;
  logic [1:0]       slot;
  logic [DIM_W-1:0] d_cur;
  logic             dup_cur;

  wire bit_end   = (phase == PW'(OSC_PER_BIT - 1));
  wire slot_end  = bit_end && (bitc == BW'(SLOT_BITS - 1));
  wire last_slot = dup_cur ? (slot == 2'd1) : (slot == 2'd2);
  wire cyc_end   = slot_end && last_slot;

  wire [DIM_W-1:0] d_next = (dim_code > DIM_W'(DIM_MAX)) ? DIM_W'(DIM_MAX) : dim_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      bitc    <= '0;
      slot    <= '0;
      d_cur   <= '0;
      dup_cur <= 1'b1;
    end else begin
      phase <= bit_end ? '0 : phase + 1'b1;
      if (bit_end) bitc <= slot_end ? '0 : bitc + 1'b1;
      if (slot_end) slot <= last_slot ? 2'd0 : slot + 2'd1;
      if (cyc_end) begin
        d_cur   <= d_next;
        dup_cur <= duplex_sel;
      end
    end
  end

  wire seg_win  = (d_cur != '0) && (WW'(bitc) < WW'(d_cur) + WW'(LEAD));
  wire grid_win = seg_win && (WW'(bitc) >= WW'(LEAD));

  logic [1:0] sel;
  assign sel = master_sel ? (seg_win ? slot + 2'd1 : 2'd0)
                          : (dim_in ? {sync_in2, sync_in1} : 2'd0);

  always_comb begin
    case (sel)
      2'd1:    seg = pat_g1;
      2'd2:    seg = pat_g2;
      2'd3:    seg = pat_g3;
      default: seg = '0;
    endcase
  end

  assign grid_n  = (master_sel && grid_win) ? ~(3'b001 << slot) : 3'b111;
  assign dim_out = master_sel && seg_win;
  assign {sync_out2, sync_out1} = (master_sel && seg_win) ? slot + 2'd1 : 2'd0;

  assert_one_grid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~grid_n) <= 1);

  assert_grid_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_n != 3'b111 && $past(grid_n) == 3'b111 && $past(master_sel)) |-> $past(dim_out));

  assert_sync_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dim_out |-> (sync_out1 || sync_out2));

  assert_dim_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    d_cur <= DIM_W'(DIM_MAX));

  assert_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && d_cur == '0) |-> (grid_n == 3'b111 && !dim_out && seg == '0));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (d_cur != $past(d_cur)) |-> (slot == 2'd0 && bitc == '0 && phase == '0));
endmodule

// File: tb/tb_vfd_grid_scan.sv
module tb_vfd_grid_scan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic duplex_sel, master_sel, dim_in, sync_in1, sync_in2;
  logic [9:0] dim_code;
  logic [55:0] pat_g1, pat_g2, pat_g3, seg;
  logic [2:0] grid_n;
  logic dim_out, sync_out1, sync_out2;

  vfd_grid_scan dut (
    .clk(clk), .rst_n(rst_n), .duplex_sel(duplex_sel), .master_sel(master_sel),
    .dim_code(dim_code), .pat_g1(pat_g1), .pat_g2(pat_g2), .pat_g3(pat_g3),
    .dim_in(dim_in), .sync_in1(sync_in1), .sync_in2(sync_in2),
    .grid_n(grid_n), .seg(seg), .dim_out(dim_out),
    .sync_out1(sync_out1), .sync_out2(sync_out2));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, tick = 0;
  bit done = 0;
  always @(posedge clk) if (rst_n) tick <= tick + 1;

  // reference timing model: position within the display cycle in clocks
  int mpos = 0, mD = 0;
  bit mdup = 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpos <= 0; mD <= 0; mdup <= 1;
    end else if (mpos == (mdup ? 8192 : 12288) - 1) begin
      mpos <= 0;
      mD   <= (dim_code > 10'd1016) ? 1016 : int'(dim_code);
      mdup <= duplex_sel;
    end else mpos <= mpos + 1;
  end

  typedef struct { int t; string tag; } chk_t;
  chk_t q[$];

  task automatic compare(string tag);
    logic [2:0] eg = 3'b111;
    logic [55:0] es = '0;
    logic ed = 0, e1 = 0, e2 = 0;
    int sl = mpos / 4096;
    int bt = (mpos % 4096) / 4;
    if (master_sel) begin
      if (mD != 0 && bt < mD + 3) begin
        ed = 1;
        es = (sl == 0) ? pat_g1 : (sl == 1) ? pat_g2 : pat_g3;
        e1 = (sl != 1);
        e2 = (sl != 0);
        if (bt >= 3) eg[sl] = 1'b0;
      end
    end else if (dim_in) begin
      if (sync_in1 && !sync_in2) es = pat_g1;
      else if (!sync_in1 && sync_in2) es = pat_g2;
      else if (sync_in1 && sync_in2) es = pat_g3;
    end
    checks++;
    if ({grid_n, seg, dim_out, sync_out1, sync_out2} !== {eg, es, ed, e1, e2}) begin
      failures++;
      $display("FAIL %s tick=%0d grid=%b seg=%h dim=%b sync=%b%b exp grid=%b seg=%h dim=%b sync=%b%b",
               tag, tick, grid_n, seg, dim_out, sync_out1, sync_out2, eg, es, ed, e1, e2);
    end
  endtask

  task automatic wait_tick(int t);
    while (tick < t) @(negedge clk);
  endtask

  task automatic chk_at(int t, string tag);
    wait_tick(t);
    q.push_back('{t, tag});
  endtask

  always begin
    @(negedge clk); #2;
    while (q.size() > 0 && q[0].t <= tick) begin
      compare(q[0].tag);
      void'(q.pop_front());
    end
  end

  localparam int C1 = 8192, C2 = 16384, C3 = 28672, C4 = 40960;

  initial begin
    duplex_sel = 1; master_sel = 1; dim_code = 10'd1023;
    pat_g1 = {28{2'b01}}; pat_g2 = {28{2'b10}}; pat_g3 = 56'hF0F0_F0F0_F0F0_F0;
    dim_in = 1; sync_in1 = 1; sync_in2 = 1;
    repeat (3) @(negedge clk);
    #2 compare("R1");
    @(negedge clk) rst_n = 1;
    chk_at(100, "R7");
    chk_at(C1 - 1, "R1");
    chk_at(C1 + 4*1 + 2, "R4");
    chk_at(C1 + 4*2 + 3, "R3");
    chk_at(C1 + 4*3, "R3");
    chk_at(C1 + 4*1018 + 3, "R6");
    chk_at(C1 + 4*1019, "R6");
    wait_tick(C1 + 4*1020);
    dim_code = 10'd64; duplex_sel = 0; dim_in = 0; sync_in1 = 0; sync_in2 = 0;
    chk_at(C1 + 4096 + 4*500 + 2, "R9");
    chk_at(C1 + 4096 + 4*1018 + 2, "R8");
    chk_at(C2 - 1, "R2");
    chk_at(C2 + 4*66 + 2, "R4");
    chk_at(C2 + 4*67, "R4");
    chk_at(C2 + 4096 + 4*10, "R5");
    chk_at(C2 + 8192 + 4*10 + 1, "R2");
    wait_tick(C2 + 8192 + 4*500);
    dim_code = 10'd0;
    chk_at(C3 + 4*5 + 2, "R7");
    chk_at(C3 + 8192 + 4*5, "R7");
    wait_tick(C4 + 10);
    master_sel = 0; dim_code = 10'd500; dim_in = 1; sync_in1 = 1; sync_in2 = 0;
    chk_at(C4 + 10, "R10");
    @(negedge clk); sync_in1 = 0; sync_in2 = 1;
    chk_at(C4 + 11, "R10");
    @(negedge clk); sync_in1 = 1; sync_in2 = 1;
    chk_at(C4 + 12, "R10");
    @(negedge clk); dim_in = 0;
    chk_at(C4 + 13, "R10");
    @(negedge clk); dim_in = 1; sync_in1 = 0; sync_in2 = 0;
    chk_at(C4 + 14, "R11");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired tick=%0d exp completion", tick);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule